// File: doc/BRIEF.md
# Serial Port Register and Status Unit

This block is the register and status front end of a FIFO-buffered serial port. A host reaches it through a simple synchronous bus. Each cycle carries one access: an enable, a write flag, a byte offset and write data. Read data is returned combinationally in the same cycle. The block holds the mode, bit-rate, control, FIFO-control and port registers. It keeps five status flags that software clears by writing zeros. It drives the transmit and receive interrupt lines.

Writing the transmit data offset produces a one-cycle strobe carrying the byte towards a serializer. On the receive side the block drives a separate FIFO. It pops a byte when the receive data offset is read, requests a flush, and selects the receive trigger level. It takes three single-cycle event inputs from the receive path: receive-full, data-ready and break. The transmitter is modelled as always ready. While transmit is enabled, a status read re-arms the transmit-end and transmit-empty flags.

Top module: `sport_regs`

## Requirements
- R1: After reset the registers read as follows. Mode (offset 0x00) is 0x00, bit rate (0x04) is 0xFF, control (0x08) is 0x20, FIFO control (0x18) is 0x0000 and port (0x20) is 0x00. Status (0x10) reads 0x60. Both interrupt lines are low.
- R2: Written values are masked before they are stored: mode by 0x7B, control by 0xFA, port by 0xF3. Bit rate keeps all 8 bits and FIFO control keeps all 16 bits. Each reads back as stored.
- R3: Status layout: bit 6 is transmit-end, bit 5 transmit-empty, bit 4 break, bit 1 receive-full and bit 0 data-ready; all other bits read 0. A status write clears every listed flag whose bit is written 0 and leaves a flag unchanged where its bit is 1.
- R4: A status read returns the flags as they were before the read. If control bit 5 is set, the read then sets transmit-end and transmit-empty. If control bit 5 is clear, the read changes nothing.
- R5: A write to offset 0x0C clears transmit-empty. In the next cycle `tx_stb` is high for one cycle and `tx_byte` carries the written byte. The byte reads back at 0x0C.
- R6: A control write with bit 5 at 0 sets transmit-end.
- R7: `irq_tx` equals the stored control bit 7.
- R8: `irq_rx` rises after an `ev_rxfull` event if control bit 6 was set before the event. It falls after a status write with bit 1 or bit 0 at 0, or after a control write with bit 6 at 0.
- R9: `rx_trig` equals the stored FIFO-control bits 7:6. A FIFO-control write with bit 1 set pulses `rx_flush` in the same cycle and clears receive-full.
- R10: A read of 0x14 returns `rx_head` and pulses `rx_pop` when `rx_count` is nonzero. After the pop, receive-full clears if fewer bytes remain than the trigger level: 1, 4, 8 or 14 for `rx_trig` codes 0 to 3. A read of 0x14 with `rx_count` at 0 returns 0 and does not pop.
- R11: A read of 0x1C returns `rx_count`. Offset 0x24 reads 0. Writes to 0x14, 0x1C and 0x24 have no effect.
- R12: An access to any other offset is unmapped; this includes unaligned offsets and offsets above 0x24. It raises `bus_err` for one cycle in the next cycle. A read of it returns 0 and a write to it changes nothing.
- R13: An event input that sets a flag wins over a clear of that flag by a bus access in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, same cycle |
| bus_err | output | 1 | Unmapped-access pulse, one cycle later |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| tx_stb | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| rx_head | input | 8 | Byte at the receive FIFO head |
| rx_count | input | CW | Receive FIFO fill level |
| rx_pop | output | 1 | Pop one receive byte |
| rx_flush | output | 1 | Flush the receive FIFO |
| rx_trig | output | 2 | Receive trigger code |
| ev_rxfull | input | 1 | Receive-full set event |
| ev_ready | input | 1 | Data-ready set event |
| ev_break | input | 1 | Break set event |

## Verification
The status flags are tested under several patterns. Transmit data writes are followed by status reads with transmit enabled and with it disabled, which separates the re-arm from a plain read. Write-zero and write-one patterns on the status register show each flag's clear as independent of the others.

Receive pops are tested with the FIFO above, at and below the trigger level, and with it empty. This exposes comparison slips by one and pops from an empty FIFO. Events that coincide with clearing writes show which side has priority. A behavioural model that uses a byte queue as the FIFO is compared with every output on every cycle.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int NREG     = 10;
  localparam int IX_MODE  = 0;
  localparam int IX_BRATE = 1;
  localparam int IX_CTRL  = 2;
  localparam int IX_TXD   = 3;
  localparam int IX_STAT  = 4;
  localparam int IX_RXD   = 5;
  localparam int IX_FCTL  = 6;
  localparam int IX_RCNT  = 7;
  localparam int IX_PORT  = 8;
  localparam int IX_LINE  = 9;

  localparam logic [7:0] MODE_MASK = 8'h7B;
  localparam logic [7:0] CTRL_MASK = 8'hFA;
  localparam logic [7:0] PORT_MASK = 8'hF3;

  typedef struct packed {
    logic tend;
    logic tde;
    logic brk;
    logic rdf;
    logic dr;
  } flags_t;

  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/sport_decode.sv
module sport_decode #(
  parameter int AW = 6
) (
  input  logic                       en,
  input  logic [AW-1:0]              addr,
  output logic [sport_pkg::NREG-1:0] sel,
  output logic                       hit
);
  for (genvar i = 0; i < sport_pkg::NREG; i++) begin : g_sel
    assign sel[i] = en && (addr == AW'(i * 4));
  end
  assign hit = |sel;
endmodule

// File: rtl/sport_flags.sv
module sport_flags
  import sport_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stat,
  input  flags_t        stat_keep,
  input  logic          rd_stat,
  input  logic          wr_ctrl,
  input  logic          ctrl_w5,
  input  logic          ctrl_w6,
  input  logic          wr_txd,
  input  logic          tx_en,
  input  logic          rx_ie,
  input  logic          pop,
  input  logic [CW-1:0] cnt,
  input  logic [1:0]    trig,
  input  logic          flush,
  input  logic          set_rdf,
  input  logic          set_dr,
  input  logic          set_brk,
  output flags_t        flags,
  output logic          irq_rx
);
  flags_t fl_d;
  logic   irq_d;
  logic   upd;

  always_comb begin
    fl_d  = flags;
    irq_d = irq_rx;
    if (wr_ctrl && !ctrl_w5) fl_d.tend = 1'b1;
    if (wr_ctrl && !ctrl_w6) irq_d = 1'b0;
    if (wr_txd) fl_d.tde = 1'b0;
    if (wr_stat) begin
      fl_d = fl_d & stat_keep;
      if (!stat_keep.rdf || !stat_keep.dr) irq_d = 1'b0;
    end
    if (rd_stat && tx_en) begin
      fl_d.tend = 1'b1;
      fl_d.tde  = 1'b1;
    end
    if (pop && (32'(cnt) <= trig_level(trig))) fl_d.rdf = 1'b0;
    if (flush) fl_d.rdf = 1'b0;
    if (set_rdf) begin
      fl_d.rdf = 1'b1;
      if (rx_ie) irq_d = 1'b1;
    end
    if (set_dr)  fl_d.dr  = 1'b1;
    if (set_brk) fl_d.brk = 1'b1;
  end

  assign upd = wr_stat | rd_stat | wr_ctrl | wr_txd | pop | flush |
               set_rdf | set_dr | set_brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= flags_t'(5'b11000);
      irq_rx <= 1'b0;
    end else if (upd) begin
      flags  <= fl_d;
      irq_rx <= irq_d;
    end
  end
endmodule

// File: rtl/sport_regs.sv
module sport_regs
  import sport_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          tx_stb,
  output logic [7:0]    tx_byte,
  input  logic [7:0]    rx_head,
  input  logic [CW-1:0] rx_count,
  output logic          rx_pop,
  output logic          rx_flush,
  output logic [1:0]    rx_trig,
  input  logic          ev_rxfull,
  input  logic          ev_ready,
  input  logic          ev_break
);
  logic [NREG-1:0] sel;
  logic            hit;
  logic [NREG-1:0] wr_sel;
  logic [NREG-1:0] rd_sel;

  logic [7:0]    mode_q, brate_q, ctrl_q, port_q, txd_q;
  logic [DW-1:0] fctl_q;
  logic [7:0]    mode_d, ctrl_d, port_d;
  logic          err_q, stb_q;
  flags_t        flags;
  flags_t        stat_keep;

  sport_decode #(.AW(AW)) u_dec (
    .en   (bus_en),
    .addr (bus_addr),
    .sel  (sel),
    .hit  (hit)
  );

  assign wr_sel = bus_we ? sel : '0;
  assign rd_sel = bus_we ? '0  : sel;

  assign mode_d = bus_wdata[7:0] & MODE_MASK;
  assign ctrl_d = bus_wdata[7:0] & CTRL_MASK;
  assign port_d = bus_wdata[7:0] & PORT_MASK;
  assign stat_keep = '{tend: bus_wdata[6], tde: bus_wdata[5], brk: bus_wdata[4],
                       rdf: bus_wdata[1], dr: bus_wdata[0]};

  assign rx_pop   = rd_sel[IX_RXD] && (rx_count != '0);
  assign rx_flush = wr_sel[IX_FCTL] && bus_wdata[1];
  assign rx_trig  = fctl_q[7:6];
  assign irq_tx   = ctrl_q[7];
  assign tx_byte  = txd_q;
  assign tx_stb   = stb_q;
  assign bus_err  = err_q;

  sport_flags #(.CW(CW)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stat   (wr_sel[IX_STAT]),
    .stat_keep (stat_keep),
    .rd_stat   (rd_sel[IX_STAT]),
    .wr_ctrl   (wr_sel[IX_CTRL]),
    .ctrl_w5   (bus_wdata[5]),
    .ctrl_w6   (bus_wdata[6]),
    .wr_txd    (wr_sel[IX_TXD]),
    .tx_en     (ctrl_q[5]),
    .rx_ie     (ctrl_q[6]),
    .pop       (rx_pop),
    .cnt       (rx_count),
    .trig      (fctl_q[7:6]),
    .flush     (rx_flush),
    .set_rdf   (ev_rxfull),
    .set_dr    (ev_ready),
    .set_brk   (ev_break),
    .flags     (flags),
    .irq_rx    (irq_rx)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_sel[IX_MODE])  bus_rdata = DW'(mode_q);
    if (rd_sel[IX_BRATE]) bus_rdata = DW'(brate_q);
    if (rd_sel[IX_CTRL])  bus_rdata = DW'(ctrl_q);
    if (rd_sel[IX_TXD])   bus_rdata = DW'(txd_q);
    if (rd_sel[IX_STAT])  bus_rdata = DW'({1'b0, flags.tend, flags.tde, flags.brk,
                                           2'b00, flags.rdf, flags.dr});
    if (rx_pop)           bus_rdata = DW'(rx_head);
    if (rd_sel[IX_FCTL])  bus_rdata = fctl_q;
    if (rd_sel[IX_RCNT])  bus_rdata = DW'(rx_count);
    if (rd_sel[IX_PORT])  bus_rdata = DW'(port_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 8'h00;
      brate_q <= 8'hFF;
      ctrl_q  <= 8'h20;
      port_q  <= 8'h00;
      txd_q   <= 8'h00;
      fctl_q  <= '0;
    end else begin
      if (wr_sel[IX_MODE])  mode_q  <= mode_d;
      if (wr_sel[IX_BRATE]) brate_q <= bus_wdata[7:0];
      if (wr_sel[IX_CTRL])  ctrl_q  <= ctrl_d;
      if (wr_sel[IX_PORT])  port_q  <= port_d;
      if (wr_sel[IX_TXD])   txd_q   <= bus_wdata[7:0];
      if (wr_sel[IX_FCTL])  fctl_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      err_q <= bus_en && !hit;
      stb_q <= wr_sel[IX_TXD];
    end
  end
endmodule

// File: rtl/sport_regs_chk.sv
module sport_regs_chk #(
  parameter int AW = 6,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    wdata_lo,
  input logic          bus_err,
  input logic          irq_tx,
  input logic          irq_rx,
  input logic          tx_stb,
  input logic [7:0]    tx_byte,
  input logic [CW-1:0] rx_count,
  input logic          rx_pop,
  input logic          ev_rxfull
);
  logic unmapped;
  assign unmapped = bus_en && !((bus_addr[1:0] == 2'b00) && (bus_addr <= AW'(36)));

  a_r5_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == AW'(12)) |=> (tx_stb && tx_byte == $past(wdata_lo)));

  a_r7_irq_tx_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == AW'(8)) |=> (irq_tx == $past(wdata_lo[7])));

  a_r8_irq_rx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == AW'(8) && !wdata_lo[6] && !ev_rxfull) |=> !irq_rx);

  a_r10_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (rx_count != '0 && !bus_we));

  a_r12_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |=> bus_err);

  a_r12_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !unmapped |=> !bus_err);
endmodule

bind sport_regs sport_regs_chk #(.AW(AW), .CW(CW)) u_chk (.wdata_lo(bus_wdata[7:0]), .*);

// File: tb/tb_sport_regs.sv
module tb_sport_regs;
  localparam int CLK_P = 10;
  localparam int AW = 6, DW = 16, DEPTH = 16, CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_err, irq_tx, irq_rx, tx_stb, rx_pop, rx_flush;
  logic [7:0] tx_byte;
  logic [7:0] rx_head = '0;
  logic [CW-1:0] rx_count = '0;
  logic [1:0] rx_trig;
  logic ev_rxfull = 1'b0, ev_ready = 1'b0, ev_break = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sport_regs #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (.*);

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // behavioural model
  logic [7:0]  m_mode, m_brate, m_ctrl, m_port, m_td;
  logic [15:0] m_fcr;
  bit m_tend, m_tde, m_brk, m_rdf, m_dr, m_irq, m_err, m_stb;
  logic [7:0] q[$];
  int lv[4] = '{1, 4, 8, 14};
  logic [15:0] last_rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic refresh();
    rx_count = CW'(q.size());
    rx_head  = (q.size() != 0) ? q[0] : 8'h00;
  endtask

  function automatic bit mapped(input logic [AW-1:0] a);
    return (a[1:0] == 2'b00) && (a <= 6'h24);
  endfunction

  function automatic logic [15:0] mread();
    if (!bus_en || bus_we) return 16'h0;
    case (bus_addr)
      6'h00: return {8'h0, m_mode};
      6'h04: return {8'h0, m_brate};
      6'h08: return {8'h0, m_ctrl};
      6'h0C: return {8'h0, m_td};
      6'h10: return {9'h0, m_tend, m_tde, m_brk, 2'b00, m_rdf, m_dr};
      6'h14: return (q.size() != 0) ? {8'h0, q[0]} : 16'h0;
      6'h18: return m_fcr;
      6'h1C: return 16'(q.size());
      6'h20: return {8'h0, m_port};
      default: return 16'h0;
    endcase
  endfunction

  task automatic commit(input bit ep, input bit ef);
    logic [7:0] oc = m_ctrl;
    logic [15:0] w = bus_wdata;
    m_err = bus_en && !mapped(bus_addr);
    m_stb = bus_en && bus_we && bus_addr == 6'h0C;
    if (bus_en && bus_we) begin
      case (bus_addr)
        6'h00: m_mode = w[7:0] & 8'h7B;
        6'h04: m_brate = w[7:0];
        6'h08: begin
          m_ctrl = w[7:0] & 8'hFA;
          if (!w[5]) m_tend = 1;
          if (!w[6]) m_irq = 0;
        end
        6'h0C: begin m_td = w[7:0]; m_tde = 0; end
        6'h10: begin
          if (!w[6]) m_tend = 0;
          if (!w[5]) m_tde = 0;
          if (!w[4]) m_brk = 0;
          if (!w[1]) m_rdf = 0;
          if (!w[0]) m_dr = 0;
          if (!w[1] || !w[0]) m_irq = 0;
        end
        6'h18: m_fcr = w;
        6'h20: m_port = w[7:0] & 8'hF3;
        default: ;
      endcase
    end else if (bus_en) begin
      if (bus_addr == 6'h10 && oc[5]) begin m_tend = 1; m_tde = 1; end
    end
    if (ep) begin
      void'(q.pop_front());
      if (q.size() < lv[m_fcr[7:6]]) m_rdf = 0;
    end
    if (ef) begin q.delete(); m_rdf = 0; end
    if (ev_rxfull) begin m_rdf = 1; if (oc[6]) m_irq = 1; end
    if (ev_ready) m_dr = 1;
    if (ev_break) m_brk = 1;
    refresh();
  endtask

  task automatic step(input string tag);
    logic [15:0] er;
    bit ep, ef;
    #(CLK_P/4);
    er = mread();
    ep = bus_en && !bus_we && bus_addr == 6'h14 && q.size() != 0;
    ef = bus_en && bus_we && bus_addr == 6'h18 && bus_wdata[1];
    chk(tag, bus_rdata, er);
    chk("R10 pop", rx_pop, ep);
    chk("R9 flush", rx_flush, ef);
    chk("R12 err", bus_err, m_err);
    chk("R5 stb", tx_stb, m_stb);
    chk("R5 byte", tx_byte, m_td);
    chk("R7 irq_tx", irq_tx, m_ctrl[7]);
    chk("R8 irq_rx", irq_rx, m_irq);
    chk("R9 trig", rx_trig, m_fcr[7:6]);
    last_rd = bus_rdata;
    @(posedge clk);
    commit(ep, ef);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input string tag);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    step(tag);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
    bus_en = 1; bus_we = 0; bus_addr = a;
    step(tag);
    bus_en = 0;
    chk(tag, last_rd, exp);
  endtask

  task automatic idle(input string tag);
    step(tag);
  endtask

  task automatic event_rxfull();
    ev_rxfull = 1; step("R8 event"); ev_rxfull = 0;
  endtask

  task automatic push(input logic [7:0] b);
    q.push_back(b);
    refresh();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    m_mode = 8'h00; m_brate = 8'hFF; m_ctrl = 8'h20; m_port = 8'h00; m_td = 8'h00;
    m_fcr = 16'h0; m_tend = 1; m_tde = 1; m_brk = 0; m_rdf = 0; m_dr = 0;
    m_irq = 0; m_err = 0; m_stb = 0;
    refresh();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 idle");

    // R1 reset values
    rd(6'h00, 16'h00, "R1 mode");
    rd(6'h04, 16'hFF, "R1 brate");
    rd(6'h08, 16'h20, "R1 ctrl");
    rd(6'h18, 16'h00, "R1 fctl");
    rd(6'h20, 16'h00, "R1 port");
    rd(6'h10, 16'h60, "R1 status");

    // R2 masks, R7 irq_tx
    wr(6'h00, 16'h00FF, "R2 mode wr");  rd(6'h00, 16'h7B, "R2 mode");
    wr(6'h04, 16'h005A, "R2 brate wr"); rd(6'h04, 16'h5A, "R2 brate");
    wr(6'h20, 16'h00FF, "R2 port wr");  rd(6'h20, 16'hF3, "R2 port");
    wr(6'h08, 16'h00FF, "R2 ctrl wr");  rd(6'h08, 16'hFA, "R2 ctrl");
    chk("R7 irq_tx high", irq_tx, 1'b1);

    // R5, R4, R3, R6
    wr(6'h08, 16'h0000, "R7 ctrl off");
    chk("R7 irq_tx low", irq_tx, 1'b0);
    wr(6'h0C, 16'h00A5, "R5 txd wr");
    chk("R5 strobe", {tx_stb, tx_byte}, {1'b1, 8'hA5});
    rd(6'h0C, 16'hA5, "R5 txd readback");
    rd(6'h10, 16'h40, "R4 status no rearm a");
    rd(6'h10, 16'h40, "R4 status no rearm b");
    wr(6'h10, 16'h00BF, "R3 clear tend");
    rd(6'h10, 16'h00, "R3 status cleared");
    wr(6'h08, 16'h0000, "R6 ctrl bit5 clear");
    rd(6'h10, 16'h40, "R6 tend set");
    wr(6'h08, 16'h0020, "R4 tx enable");
    rd(6'h10, 16'h40, "R4 read before rearm");
    rd(6'h10, 16'h60, "R4 rearmed");

    // R8 receive interrupt
    wr(6'h08, 16'h0060, "R8 rx ie");
    push(8'h11); push(8'h22); push(8'h33);
    event_rxfull();
    chk("R8 irq set", irq_rx, 1'b1);
    ev_ready = 1; step("R3 ready"); ev_ready = 0;
    rd(6'h10, 16'h63, "R3 rdf dr");
    wr(6'h10, 16'h00FE, "R8 clear dr");
    chk("R8 irq cleared by status", irq_rx, 1'b0);
    rd(6'h10, 16'h62, "R3 dr only cleared");
    event_rxfull();
    wr(6'h08, 16'h0020, "R8 ctrl bit6 clear");
    chk("R8 irq cleared by ctrl", irq_rx, 1'b0);
    ev_break = 1; step("R3 break"); ev_break = 0;
    rd(6'h10, 16'h72, "R3 break set");
    wr(6'h10, 16'h00EF, "R3 clear break");
    rd(6'h10, 16'h62, "R3 break cleared");

    // R9 trigger, R10 pops, R11 count
    wr(6'h18, 16'h0040, "R9 trig 1");
    chk("R9 trig out", rx_trig, 2'd1);
    rd(6'h1C, 16'h3, "R11 count");
    rd(6'h14, 16'h11, "R10 pop below trig");
    rd(6'h10, 16'h60, "R10 rdf cleared");
    wr(6'h18, 16'h0000, "R9 trig 0");
    push(8'h44); push(8'h55);
    event_rxfull();
    rd(6'h14, 16'h22, "R10 pop above trig");
    rd(6'h10, 16'h62, "R10 rdf kept");
    rd(6'h14, 16'h33, "R10 pop");
    rd(6'h14, 16'h44, "R10 pop");
    rd(6'h14, 16'h55, "R10 pop last");
    rd(6'h10, 16'h60, "R10 rdf at empty");
    rd(6'h14, 16'h00, "R10 empty read");
    rd(6'h1C, 16'h0, "R11 count empty");

    // R9 flush
    push(8'h66); push(8'h77);
    event_rxfull();
    wr(6'h18, 16'h12C2, "R9 flush");
    rd(6'h10, 16'h60, "R9 rdf flushed");
    rd(6'h18, 16'h12C2, "R2 fctl full");
    chk("R9 trig 3", rx_trig, 2'd3);

    // R11 read-only / ignored offsets
    push(8'h88);
    wr(6'h24, 16'hFFFF, "R11 line wr");
    rd(6'h24, 16'h0, "R11 line read");
    wr(6'h1C, 16'h0009, "R11 count wr");
    rd(6'h1C, 16'h1, "R11 count unchanged");
    wr(6'h14, 16'h0099, "R11 rxd wr");
    rd(6'h14, 16'h88, "R11 rxd unchanged");

    // R12 unmapped
    rd(6'h28, 16'h0, "R12 read high");
    chk("R12 err pulse", bus_err, 1'b1);
    idle("R12 err drop");
    rd(6'h02, 16'h0, "R12 unaligned");
    wr(6'h3C, 16'hFFFF, "R12 write ignored");
    chk("R12 err on write", bus_err, 1'b1);
    rd(6'h00, 16'h7B, "R12 mode intact");

    // R13 set beats clear
    ev_rxfull = 1;
    wr(6'h10, 16'h00FD, "R13 set vs clear");
    ev_rxfull = 0;
    rd(6'h10, 16'h62, "R13 rdf kept");

    idle("end");
    finish_run();
  end
endmodule